// File: doc/BRIEF.md
# SPI Register-Access Host Sequencer

This block lets on-chip logic reach the registers of a remote board controller over a four-wire SPI link. A request gives a 32-bit register address, a direction flag and 16 bits of write data. The block turns that request into a series of 24-bit serial frames. Each frame is sent under its own chip-select assertion. When the request is finished, the block pulses `done` and, for a read, presents the 16-bit result on `rdata`.

The remote side holds its target address in three small address registers, and it exposes a data window through a fourth register. The sequencer keeps a copy of the last address it completed. When the next address differs from that copy, or when the copy is invalid after reset, the sequencer first loads the three address registers. When the address repeats, it goes straight to the data window. The remote side returns read data one frame late, so a read always sends two read frames to the data window and keeps only the result of the second one.

The serial clock comes from a runtime-programmable divider of the system clock. To reach a target rate, choose the smallest divider value whose resulting rate does not exceed the target. This rounds the rate down, for example to 6 MHz from a 48 MHz reference when the target is 7 MHz.

Top module: `spiRegHost`

## Requirements
- R1: `spiCsN` is high and `spiSclk` is low whenever no frame is in progress. `spiCsN` goes low for exactly one 24-bit frame, then returns high.
- R2: The first byte of a frame has the register index in bits 1:0 and the direction in bit 3 (1 = read, 0 = write). Bits 7:4 and bit 2 are zero.
- R3: The second byte of a frame is the low byte of the 16-bit data field, and the third byte is the high byte. A read frame sends zero in both of these bytes.
- R4: The bits received during the first byte are dropped. The second and third received bytes form the returned word, with the second byte as the low byte.
- R5: An access whose 32-bit address differs from the last completed address is preceded by three write frames, in this order:
  - index 0 carrying address bits 15:0;
  - index 1 carrying address bits 23:16 in the low byte;
  - index 2 carrying address bits 27:26 in data bits 1:0.

  The first access after reset always sends these frames, even to address 0.
- R6: An access to the same address as the last completed access sends no address frames.
- R7: A write access ends with one write frame to index 3 that carries the write data.
- R8: A read access sends two read frames to index 3. `rdata` takes the value received in the second frame.
- R9: Bits are sent MSB first in SPI mode 0. `spiMosi` is stable while `spiSclk` is high, and `spiMiso` is sampled on the rising edge. Each `spiSclk` level lasts `clkDiv`+1 system clocks.
- R10: `busy` is high from the cycle after a request is accepted until `done` pulses. `done` lasts one cycle, with `busy` low during it. A `reqValid` that arrives while `busy` is high sends no frames and has no effect.
- R11: The last-address copy changes only when an access completes, so a request ignored while busy does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkDiv | input | DIV_W | Serial clock half-period minus one, in system clocks |
| reqValid | input | 1 | Request strobe, accepted when busy is low |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqAddr | input | 32 | Remote register address |
| reqWdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, updated when a read completes |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data to the remote side |
| spiCsN | output | 1 | Active-low chip select |
| spiMiso | input | 1 | Serial data from the remote side |

## Verification
A stale or corrupt last-address copy shows up in the very next access as address frames that are missing or extra. The frame-by-frame comparison against expected frame contents catches this when `spiCsN` rises at the end of the first mismatching frame. If the step sequencer loses track of the read step, the data-window read sends one frame too few. The discarded stale word then appears on `rdata` at the `done` pulse, which a slave model with a one-frame delay exposes at once. A divider or shift fault breaks the measured level widths of `spiSclk`, and the per-clock count detects it within one half-period.

// File: rtl/spiRegHostPkg.sv
package spiRegHostPkg;
  // One-cycle command from the sequencer to the frame engine.
  typedef struct packed {
    logic        start;
    logic        rd;
    logic [1:0]  idx;
    logic [15:0] data;
  } frameCmdT;

  typedef enum logic [2:0] {
    STP_ALO   = 3'd0,
    STP_AHI   = 3'd1,
    STP_SEL   = 3'd2,
    STP_DATA  = 3'd3,
    STP_READ2 = 3'd4
  } stepT;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seqStateT;
endpackage

// File: rtl/spiFrameEngine.sv
module spiFrameEngine
  import spiRegHostPkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] clkDiv,
  input  frameCmdT         cmd,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             csN,
  output logic             frameDone,
  output logic [15:0]      rxWord
);
  localparam int FRAME_BITS = 24;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

  logic                  active;
  logic [DIV_W-1:0]      cnt;
  logic [BIT_W-1:0]      bitCnt;
  logic [FRAME_BITS-1:0] txSh;
  logic [FRAME_BITS-1:0] rxSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      csN       <= 1'b1;
      sclk      <= 1'b0;
      cnt       <= '0;
      bitCnt    <= '0;
      txSh      <= '0;
      rxSh      <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      if (!active) begin
        if (cmd.start) begin
          active <= 1'b1;
          csN    <= 1'b0;
          sclk   <= 1'b0;
          cnt    <= '0;
          bitCnt <= '0;
          // control byte, then data low byte, then data high byte
          txSh   <= {4'b0000, cmd.rd, 1'b0, cmd.idx, cmd.data[7:0], cmd.data[15:8]};
        end
      end else if (cnt == clkDiv) begin
        cnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rxSh <= {rxSh[FRAME_BITS-2:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitCnt == LAST_BIT) begin
            active    <= 1'b0;
            csN       <= 1'b1;
            frameDone <= 1'b1;
          end else begin
            bitCnt <= bitCnt + 1'b1;
            txSh   <= {txSh[FRAME_BITS-2:0], 1'b0};
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign mosi   = txSh[FRAME_BITS-1];
  assign rxWord = {rxSh[7:0], rxSh[15:8]};
endmodule

// File: rtl/spiAccessSeq.sv
module spiAccessSeq
  import spiRegHostPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [31:0] reqAddr,
  input  logic [15:0] reqWdata,
  input  logic        frameDone,
  input  logic [15:0] rxWord,
  output frameCmdT    cmd,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata
);
  seqStateT    state;
  stepT        step;
  logic [31:0] addrQ;
  logic [31:0] lastAddr;
  logic        lastValid;
  logic        wrQ;
  logic [15:0] wdQ;
  logic        lastStep;

  assign lastStep = (step == STP_READ2) || (step == STP_DATA && wrQ);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    cmd       = '0;
    cmd.start = (state == ST_ISSUE);
    case (step)
      STP_ALO:  begin cmd.idx = 2'd0; cmd.data = addrQ[15:0]; end
      STP_AHI:  begin cmd.idx = 2'd1; cmd.data = {8'h00, addrQ[23:16]}; end
      STP_SEL:  begin cmd.idx = 2'd2; cmd.data = {14'b0, addrQ[27:26]}; end
      STP_DATA: begin
        cmd.idx  = 2'd3;
        cmd.rd   = !wrQ;
        cmd.data = wrQ ? wdQ : 16'h0000;
      end
      default:  begin cmd.idx = 2'd3; cmd.rd = 1'b1; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      step      <= STP_ALO;
      addrQ     <= '0;
      lastAddr  <= '0;
      lastValid <= 1'b0;
      wrQ       <= 1'b0;
      wdQ       <= '0;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (reqValid) begin
          addrQ <= reqAddr;
          wrQ   <= reqWrite;
          wdQ   <= reqWdata;
          step  <= (lastValid && reqAddr == lastAddr) ? STP_DATA : STP_ALO;
          state <= ST_ISSUE;
        end
        ST_ISSUE: state <= ST_WAIT;
        default: if (frameDone) begin
          if (lastStep) begin
            done      <= 1'b1;
            lastAddr  <= addrQ;
            lastValid <= 1'b1;
            if (!wrQ) rdata <= rxWord;
            state     <= ST_IDLE;
          end else begin
            step  <= stepT'(step + 3'd1);
            state <= ST_ISSUE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spiRegHost.sv
module spiRegHost
  import spiRegHostPkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [31:0]      reqAddr,
  input  logic [15:0]      reqWdata,
  output logic             busy,
  output logic             done,
  output logic [15:0]      rdata,
  output logic             spiSclk,
  output logic             spiMosi,
  output logic             spiCsN,
  input  logic             spiMiso
);
  frameCmdT    cmd;
  logic        frameDone;
  logic [15:0] rxWord;

  spiAccessSeq seqI (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .frameDone(frameDone),
    .rxWord(rxWord), .cmd(cmd), .busy(busy), .done(done), .rdata(rdata)
  );

  spiFrameEngine #(.DIV_W(DIV_W)) engI (
    .clk(clk), .rstN(rstN), .clkDiv(clkDiv), .cmd(cmd), .miso(spiMiso),
    .sclk(spiSclk), .mosi(spiMosi), .csN(spiCsN), .frameDone(frameDone),
    .rxWord(rxWord)
  );
endmodule

// File: rtl/spiRegHostChk.sv
module spiRegHostChk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic mosi,
  input logic csN
);
  // R1
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN) csN |-> !sclk);
  // R1
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rstN) !csN |-> busy);
  // R9
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);
endmodule

bind spiRegHost spiRegHostChk chkI (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done),
  .sclk(spiSclk), .mosi(spiMosi), .csN(spiCsN)
);

// File: tb/tb_spiRegHost.sv
`timescale 1ns/1ps
module tb_spiRegHost;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [DIV_W-1:0] clkDiv = '0;
  logic             reqValid = 1'b0;
  logic             reqWrite = 1'b0;
  logic [31:0]      reqAddr = '0;
  logic [15:0]      reqWdata = '0;
  logic             busy, done;
  logic [15:0]      rdata;
  logic             spiSclk, spiMosi, spiCsN;
  logic             spiMiso = 1'b0;

  always #2 clk = ~clk;

  spiRegHost #(.DIV_W(DIV_W)) dut (.*);

  int checks = 0;
  int fails  = 0;

  // bench reference state
  logic [23:0] expQ[$];
  logic [31:0] mdlLast = '0;
  logic        mdlValid = 1'b0;
  logic [15:0] mem [int unsigned];

  // slave model state
  logic [15:0] sReg0 = '0, sReg1 = '0, sReg2 = '0, pend = 16'hDEAD;
  logic [23:0] sTx = '0, sRx = '0;
  int          sBit = 0;
  logic        pCs = 1'b1, pSclk = 1'b0;
  int          gap = 0;

  function automatic logic [15:0] dflt(input int unsigned key);
    return key[15:0] ^ {6'b0, key[25:16]} ^ 16'hA55A;
  endfunction

  function automatic int unsigned keyOf(input logic [31:0] a);
    return {6'b0, a[27:26], a[23:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // per-clock monitor and slave, away from the active edge
  always @(negedge clk) if (rstN) begin
    if (pCs && !spiCsN) begin
      gap  = 0;
      sTx  = {8'h00, pend[7:0], pend[15:8]};
      sBit = 23;
      spiMiso = sTx[23];
    end else if (spiSclk != pSclk) begin
      chk(gap == int'(clkDiv), "R9", "sclk level width", gap + 1, clkDiv + 1);
      gap = 0;
      if (spiSclk) sRx = {sRx[22:0], spiMosi};
      else if (!spiCsN && sBit > 0) begin
        sBit--;
        spiMiso = sTx[sBit];
      end
    end else if (!spiCsN) gap++;
    if (spiCsN && spiSclk) chk(0, "R1", "sclk high while deselected", 1, 0);
    if (!pCs && spiCsN) begin
      // end of frame: compare against expectation, then act as slave
      if (expQ.size() == 0) chk(0, "R10", "unexpected frame", {8'h0, sRx}, 0);
      else begin
        logic [23:0] e;
        e = expQ.pop_front();
        chk(sRx === e, "R2", "frame contents", {8'h0, sRx}, {8'h0, e});
      end
      pend = 16'hDEAD;
      case ({sRx[19], sRx[17:16]})
        3'b000: sReg0 = {sRx[7:0], sRx[15:8]};
        3'b001: sReg1 = {sRx[7:0], sRx[15:8]};
        3'b010: sReg2 = {sRx[7:0], sRx[15:8]};
        3'b011: mem[{6'b0, sReg2[1:0], sReg1[7:0], sReg0}] = {sRx[7:0], sRx[15:8]};
        3'b111: begin
          int unsigned k;
          k = {6'b0, sReg2[1:0], sReg1[7:0], sReg0};
          pend = mem.exists(k) ? mem[k] : dflt(k);
        end
        default: ;
      endcase
    end
    pCs   = spiCsN;
    pSclk = spiSclk;
  end

  function automatic logic [23:0] frm(input bit rd, input logic [1:0] idx, input logic [15:0] d);
    return {4'b0, rd, 1'b0, idx, d[7:0], d[15:8]};
  endfunction

  // R5 R6 R7 R8: build the expected frames, run one access, check completion
  task automatic access(input bit wr, input logic [31:0] a, input logic [15:0] d,
                        input bit poke);
    logic [15:0] expR;
    if (!(mdlValid && a == mdlLast)) begin
      expQ.push_back(frm(0, 2'd0, a[15:0]));
      expQ.push_back(frm(0, 2'd1, {8'h0, a[23:16]}));
      expQ.push_back(frm(0, 2'd2, {14'b0, a[27:26]}));
    end
    if (wr) expQ.push_back(frm(0, 2'd3, d));
    else begin
      expQ.push_back(frm(1, 2'd3, 16'h0));
      expQ.push_back(frm(1, 2'd3, 16'h0));
    end
    expR = mem.exists(keyOf(a)) ? mem[keyOf(a)] : dflt(keyOf(a));
    @(negedge clk);
    while (busy) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy === 1'b1, "R10", "busy after accept", busy, 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      // R11: a request while busy is ignored
      reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a ^ 32'h0400_1234; reqWdata = 16'hBEEF;
      @(negedge clk);
      reqValid = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(busy === 1'b0, "R10", "busy low with done", busy, 0);
    if (!wr) chk(rdata === expR, "R8", "read value", rdata, expR);
    @(negedge clk);
    chk(done === 1'b0, "R10", "done one cycle", done, 0);
    chk(expQ.size() == 0, "R5", "frames left unsent", expQ.size(), 0);
    mdlLast  = a;
    mdlValid = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R10", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(spiCsN === 1'b1 && spiSclk === 1'b0, "R1", "reset pins", {spiCsN, spiSclk}, 2'b10);
    chk(busy === 1'b0 && done === 1'b0, "R10", "reset status", {busy, done}, 2'b00);
    rstN = 1'b1;
    clkDiv = 8'd0;
    access(0, 32'h0000_0000, 16'h0, 0);         // R5 first access sets up even addr 0
    access(0, 32'h0000_0000, 16'h0, 0);         // R6 repeat skips setup
    clkDiv = 8'd2;
    access(1, 32'h0C12_3456, 16'h8001, 0);      // R7 write with setup
    access(0, 32'h0C12_3456, 16'h0, 0);         // R4 R8 read back through delay
    access(1, 32'h0C12_3456, 16'h7E5A, 1);      // R11 ignored request mid-access
    access(0, 32'h0C12_3456, 16'h0, 0);         // R6 still same address
    clkDiv = 8'd5;
    access(1, 32'h0812_3456, 16'h1234, 0);      // R5 select bits differ
    access(0, 32'h3812_3456, 16'h0, 0);         // R5 top bits differ, same key
    access(0, 32'h04FF_00FF, 16'h0, 0);         // R3 default content
    clkDiv = 8'd1;
    access(0, 32'h0C12_3456, 16'h0, 0);
    repeat (20) @(negedge clk);
    chk(spiCsN === 1'b1 && expQ.size() == 0, "R1", "idle at end", spiCsN, 1);
    report();
  end
endmodule